// File: doc/BRIEF.md
# Completion Event Ring Writer

This block sits behind a DMA engine's transfer logic and turns each finished transfer into a status record in a circular ring held in memory. Every completion arrives as a single-cycle handshake carrying a 4-bit completion code and a 4-bit error detail. The block packs these into a 16-byte record and writes it to the ring at the current write offset. It then advances the offset and raises a single-cycle event toward the interrupt logic.

Software reads the write offset to learn how far the ring has been filled. It returns ring space by writing its consumed byte offset to a doorbell register. The ring length is a register as well. The block refuses new completions while the slot after the current one is the slot software has not yet released. In that case the transfer side stalls until a doorbell write frees space.

Top module: `evt_ring_writer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the write offset and the doorbell offset are 0, the ring length equals its default, no record write takes place and no event is raised.
- R2: An accepted completion produces one 128-bit record on the memory port. The record's word 0 is bits 31:0 of the record. Bits 31:28 hold the completion code, where 1 means done and 4 means error. Bits 27:24 hold the error detail. Every other bit of the record is 0. The write address is the write offset as it stood before the record.
- R3: The write offset is a byte offset that always stays a multiple of 16 and stays below the ring length. It advances by 16 with each record and becomes 0 when the advance would reach the ring length.
- R4: The ring is full when the advanced write offset would equal the doorbell offset. While the ring is full, the ready output is low, a presented completion produces no write, and the write offset holds.
- R5: A config write with select 1 loads the doorbell offset, with the low 4 bits of the data forced to 0. A full ring therefore takes completions again once the doorbell moves.
- R6: A config write with select 0 loads the ring length, with the low 4 bits forced to 0. It also clears the write offset and the doorbell offset to 0. A length below 32 bytes is ignored, and every register keeps its value.
- R7: The event output is high for exactly the cycle in which a record write is presented. It is high in no other cycle.
- R8: Records appear in the order their completions were accepted, one write in the cycle after each accepted completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_valid | input | 1 | A completion is presented |
| cmpl_code | input | 4 | Completion code (1 done, 4 error) |
| cmpl_info | input | 4 | Error detail |
| cmpl_ready | output | 1 | Completion accepted this cycle when valid |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 1 | 0 ring length, 1 doorbell |
| cfg_wdata | input | PTR_W | Config write data, a byte offset or length |
| wr_ptr | output | PTR_W | Current write byte offset |
| rd_ptr | output | PTR_W | Doorbell byte offset |
| ring_len | output | PTR_W | Programmed ring length in bytes |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | PTR_W | Record byte offset in the ring |
| mem_wdata | output | 128 | Record contents |
| eob_evt | output | 1 | End-of-block event to interrupt logic |

## Verification
The hardest state to reach is the ring-full boundary combined with a wrap. Here the advance would carry the write offset back to 0, and 0 is exactly the doorbell offset, so the full check must use the wrapped value. The bench reaches it by sweeping every legal ring length of a small ring from 2 to 8 records. For each length it presents completions until the ring fills, offers one more completion that must stall, and then releases the ring with a doorbell write. The write offset therefore laps the ring several times at every length. Malformed length and doorbell values with nonzero low bits, and lengths that are too short, are written in between.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int REC_BYTES = 16;
  localparam int REC_SHIFT = 4;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int MIN_RECS  = 2;

  localparam logic [3:0] CODE_DONE = 4'd1;
  localparam logic [3:0] CODE_FAIL = 4'd4;

  typedef enum logic {
    SEL_LEN  = 1'b0,
    SEL_DBELL = 1'b1
  } cfg_sel_e;

  typedef struct packed {
    logic [3:0]  code;
    logic [3:0]  info;
  } cmpl_t;
endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int PTR_W   = 12,
  parameter int DEF_LEN = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [PTR_W-1:0] cfg_wdata,
  output logic [PTR_W-1:0] ring_len,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             len_load
);
  localparam int MIN_LEN = MIN_RECS * REC_BYTES;

  logic [PTR_W-1:0] aligned;
  logic             dbell_load;

  assign aligned    = {cfg_wdata[PTR_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
  assign len_load   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_LEN) &&
                      (aligned >= PTR_W'(MIN_LEN));
  assign dbell_load = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_DBELL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_len <= PTR_W'(DEF_LEN);
      rd_ptr   <= '0;
    end else if (len_load) begin
      ring_len <= aligned;
      rd_ptr   <= '0;
    end else if (dbell_load) begin
      rd_ptr   <= aligned;
    end
  end

  // R6
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (ring_len[REC_SHIFT-1:0] == '0) && (ring_len >= PTR_W'(MIN_LEN)));

  // R5
  dbell_align_chk: assert property (@(posedge clk) disable iff (rst)
    dbell_load && !len_load |=> rd_ptr[REC_SHIFT-1:0] == '0);
endmodule

// File: rtl/evr_ptr_unit.sv
module evr_ptr_unit
  import evr_pkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             clear,
  input  logic [PTR_W-1:0] ring_len,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full
);
  logic [PTR_W-1:0] step;
  logic [PTR_W-1:0] nxt;

  assign step = wr_ptr + PTR_W'(REC_BYTES);
  assign nxt  = (step >= ring_len) ? '0 : step;
  assign full = (nxt == rd_ptr);

  always_ff @(posedge clk) begin
    if (rst || clear) wr_ptr <= '0;
    else if (advance) wr_ptr <= nxt;
  end

  // R3
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr[REC_SHIFT-1:0] == '0) && (wr_ptr < ring_len));

  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance && !clear |=> (wr_ptr == '0) ||
      (wr_ptr == $past(wr_ptr) + PTR_W'(REC_BYTES)));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && !clear |=> $stable(wr_ptr));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> wr_ptr == '0);
endmodule

// File: rtl/evr_rec_out.sv
module evr_rec_out
  import evr_pkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  cmpl_t            cmpl,
  input  logic [PTR_W-1:0] slot,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [REC_W-1:0] mem_wdata,
  output logic             eob_evt
);
  logic [REC_W-1:0] packed_rec;

  always_comb begin
    packed_rec        = '0;
    packed_rec[31:28] = cmpl.code;
    packed_rec[27:24] = cmpl.info;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we  <= 1'b0;
      eob_evt <= 1'b0;
    end else begin
      mem_we  <= fire;
      eob_evt <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      mem_addr  <= slot;
      mem_wdata <= packed_rec;
    end
  end
endmodule

// File: rtl/evt_ring_writer.sv
module evt_ring_writer
  import evr_pkg::*;
#(
  parameter int PTR_W   = 12,
  parameter int DEF_LEN = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmpl_valid,
  input  logic [3:0]         cmpl_code,
  input  logic [3:0]         cmpl_info,
  output logic               cmpl_ready,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PTR_W-1:0]   cfg_wdata,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic [PTR_W-1:0]   ring_len,
  output logic               mem_we,
  output logic [PTR_W-1:0]   mem_addr,
  output logic [REC_W-1:0]   mem_wdata,
  output logic               eob_evt
);
  logic  full;
  logic  len_load;
  logic  accept;
  cmpl_t cur;

  assign cmpl_ready = !full;
  assign accept     = cmpl_valid && cmpl_ready;
  assign cur        = '{code: cmpl_code, info: cmpl_info};

  evr_cfg_regs #(.PTR_W(PTR_W), .DEF_LEN(DEF_LEN)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ring_len(ring_len), .rd_ptr(rd_ptr),
    .len_load(len_load)
  );

  evr_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .advance(accept), .clear(len_load),
    .ring_len(ring_len), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .full(full)
  );

  evr_rec_out #(.PTR_W(PTR_W)) u_rec (
    .clk(clk), .rst(rst), .fire(accept), .cmpl(cur), .slot(wr_ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .eob_evt(eob_evt)
  );

  // R8
  accept_write_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_we && eob_evt && (mem_addr == $past(wr_ptr)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !mem_we && !eob_evt);

  // R2
  rec_field_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_wdata[31:24] == {$past(cmpl_code), $past(cmpl_info)}));
endmodule

// File: tb/evt_ring_writer_tb_top.sv
module evt_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 8;
  localparam int DEFL = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmpl_valid = 1'b0;
  logic [3:0]    cmpl_code = '0;
  logic [3:0]    cmpl_info = '0;
  logic          cmpl_ready;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [PW-1:0] cfg_wdata = '0;
  logic [PW-1:0] wr_ptr, rd_ptr, ring_len, mem_addr;
  logic          mem_we, eob_evt;
  logic [127:0]  mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_wr = 0, m_rd = 0, m_len = DEFL;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_ring_writer #(.PTR_W(PW), .DEF_LEN(DEFL)) dut_i (
    .clk(clk), .rst(rst), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
    .cmpl_info(cmpl_info), .cmpl_ready(cmpl_ready), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .ring_len(ring_len), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .eob_evt(eob_evt)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nxt_of(int w);
    return (w + 16 >= m_len) ? 0 : w + 16;
  endfunction

  function automatic bit full_exp();
    return nxt_of(m_wr) == m_rd;
  endfunction

  task automatic check_regs(string req);
    chk({req, " wr_ptr"}, 128'(wr_ptr), 128'(m_wr));
    chk({req, " rd_ptr"}, 128'(rd_ptr), 128'(m_rd));
    chk({req, " ring_len"}, 128'(ring_len), 128'(m_len));
  endtask

  task automatic cmpl(logic [3:0] c, logic [3:0] inf);
    bit f;
    @(negedge clk);
    f = full_exp();
    chk("R4 ready", 128'(cmpl_ready), 128'(!f));
    cmpl_valid = 1'b1; cmpl_code = c; cmpl_info = inf;
    @(negedge clk);
    cmpl_valid = 1'b0;
    if (!f) begin
      chk("R7 eob", 128'(eob_evt), 128'(1));
      chk("R8 mem_we", 128'(mem_we), 128'(1));
      chk("R2 addr", 128'(mem_addr), 128'(m_wr));
      chk("R2 record", mem_wdata, {96'b0, c, inf, 24'b0});
      m_wr = nxt_of(m_wr);
      chk("R3 wr_ptr", 128'(wr_ptr), 128'(m_wr));
    end else begin
      chk("R4 no write", 128'({mem_we, eob_evt}), 128'(0));
      chk("R4 wr hold", 128'(wr_ptr), 128'(m_wr));
    end
  endtask

  task automatic cfg_wr(logic sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = PW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_rd = val & ~15;
    else if ((val & ~15) >= 32) begin
      m_len = val & ~15; m_wr = 0; m_rd = 0;
    end
    chk("R7 eob idle", 128'(eob_evt), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_regs("R1 during reset");
    chk("R1 no write", 128'({mem_we, eob_evt}), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check_regs("R1 after reset");
    chk("R1 ready", 128'(cmpl_ready), 128'(1));

    // default ring of 4 slots: three fit, fourth stalls
    cmpl(4'd1, 4'd0);
    cmpl(4'd4, 4'd7);
    cmpl(4'd1, 4'd15);
    cmpl(4'd4, 4'd3);
    // R5 doorbell with junk low bits
    cfg_wr(1'b1, 8'h25);
    check_regs("R5 doorbell");
    cmpl(4'd1, 4'd1);
    cmpl(4'd1, 4'd2);
    cmpl(4'd4, 4'd9);
    // R6 short lengths ignored, unaligned length trimmed
    cfg_wr(1'b0, 8'h1F);
    check_regs("R6 short ignored");
    cfg_wr(1'b0, 8'h00);
    check_regs("R6 zero ignored");
    cfg_wr(1'b0, 8'h47);
    check_regs("R6 trimmed");

    for (int len = 32; len <= 128; len += 16) begin
      cfg_wr(1'b0, len);
      check_regs("R6 sweep load");
      for (int i = 0; i < 3 * (len / 16); i++) begin
        cmpl((i % 2) ? 4'd1 : 4'd4, 4'(i));
        if (full_exp()) begin
          cmpl(4'd1, 4'hA);
          cfg_wr(1'b1, m_wr | (i & 15));
          check_regs("R5 release");
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule